// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block runs one page-program operation on an embedded flash array. After a start request it raises the array's write-enable control and then repeats a program loop until the page reads back clean. Each loop has three parts: a load handshake with an external data engine, a timed program pulse inside a setup window, and a verify pass over every word of the page. The width of the program pulse depends on the loop number. If the page reads back clean within the first few loops, one extra short program pulse is applied before the operation ends. If the page still fails after the retry limit, the operation ends with a failure result.

Every wait is a parameter given in clock cycles, so the block models no physical timing. The data engine owns the page buffers and the comparison arithmetic. It answers one load request before each pulse and one read request for each verify word, and reports on each read whether that word matched. A watchdog-enable output stays high for the whole operation.

Top module: `flash_pgm_seq`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, every output is 0.
- R2: A start pulse in idle raises `busy_o`, `wdt_en_o` and `arm_o`. `arm_o` stays high for exactly T_ARM cycles before `load_req_o` first rises. `wdt_en_o` equals `busy_o` in every cycle.
- R3: Each program pulse follows a fixed order. `prep_o` is high for T_PREP cycles before `pulse_o` rises, and stays high for T_HOLD cycles after `pulse_o` falls. After `prep_o` falls, all controls other than `arm_o` stay low for T_UNPREP cycles. `pulse_o` is never high while `prep_o` is low.
- R4: In a normal (non-additional) pulse, `pulse_o` is high for T_SHORT cycles in loops 1 to SHORT_LOOPS and for T_LONG cycles in later loops.
- R5: Every pulse, normal or additional, is preceded by exactly one `load_req_o`/`load_ack_i` handshake. `load_req_o` holds high until the cycle in which `load_ack_i` is seen.
- R6: Each verify pass follows a fixed order. `vfy_o` is high for T_VSET cycles before the first `dummy_wr_o` strobe. After each one-cycle `dummy_wr_o` strobe come T_VGAP quiet cycles, then `rd_req_o`, which holds until `rd_valid_i`. The pass reads PAGE_WORDS words, with `vfy_word_o` running 0 to PAGE_WORDS-1. After the pass, T_VCLR quiet cycles follow. `vfy_o` and `prep_o` are never high together.
- R7: A pass in which any word returns `rd_ok_i`=0, whatever its position in the page, starts another loop. Only a pass with no mismatch ends the loop sequence.
- R8: If a pass is clean in a loop no later than SHORT_LOOPS, exactly one additional pulse follows. It is marked by `add_pass_o`=1, is T_ADD cycles wide, and is not followed by a verify pass. A pass that first comes out clean in a later loop gets no additional pulse.
- R9: If the pass in loop N_MAX still mismatches, the operation ends with `fail_o` and not `done_o`, after exactly N_MAX normal pulses. The two results never assert together.
- R10: On any ending, `arm_o` falls and `busy_o` stays high with `arm_o` low for T_DISARM cycles. In the next cycle `done_o` or `fail_o` pulses for one cycle while `busy_o` and `wdt_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one page operation (sampled in idle) |
| load_ack_i | input | 1 | Data engine has loaded the page for the next pulse |
| rd_valid_i | input | 1 | Verify word read is complete |
| rd_ok_i | input | 1 | Verify word matched (valid with rd_valid_i) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| wdt_en_o | output | 1 | Watchdog enable, high for the whole operation |
| arm_o | output | 1 | Array write-enable control |
| prep_o | output | 1 | Program setup control |
| pulse_o | output | 1 | Program pulse control |
| vfy_o | output | 1 | Program-verify control |
| add_pass_o | output | 1 | Current pulse is the additional pass |
| load_req_o | output | 1 | Request page load before a pulse |
| dummy_wr_o | output | 1 | One-cycle dummy 0xFF write to the verify address |
| rd_req_o | output | 1 | Request the verify read of the current word |
| vfy_word_o | output | $clog2(PAGE_WORDS) | Index of the word being verified |

## Verification
All outputs are registered from the next state, so every control changes one edge after the decision that causes it. Each timed phase therefore lasts exactly its parameter in cycles, and each handshake completes one edge after the response is seen. The bench samples on the falling edge and measures each phase as a run of cycles between edges of the controls, so no check relies on a total cycle count. The emulated data engine answers on the falling edge after a request. It computes its match result from the number of pulses seen so far and a per-run threshold, and moves the failing word to a different position on each pass. Pulse counts, results and the presence of the additional pulse are compared against values worked out from the threshold, the loop limit and SHORT_LOOPS.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_LOAD, S_PREP, S_PULSE, S_HOLD, S_UNPREP,
    S_VSET, S_DMY, S_VGAP, S_RD, S_VCLR, S_DISARM
  } seq_state_t;
endpackage

// File: rtl/pgm_wait_timer.sv
module pgm_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pgm_loop_ctr.sv
module pgm_loop_ctr #(
  parameter int N_MAX       = 1000,
  parameter int SHORT_LOOPS = 6,
  parameter int LOOP_W      = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic step,
  output logic long_sel,
  output logic add_ok,
  output logic at_max
);
  logic [LOOP_W-1:0] loop_n;

  always_ff @(posedge clk) begin
    if (rst)                                  loop_n <= '0;
    else if (init)                            loop_n <= LOOP_W'(1);
    else if (step && (32'(loop_n) < N_MAX))   loop_n <= loop_n + 1'b1;
  end

  assign long_sel = 32'(loop_n) > SHORT_LOOPS;
  assign add_ok   = 32'(loop_n) <= SHORT_LOOPS;
  assign at_max   = 32'(loop_n) >= N_MAX;

  // R9
  loop_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(loop_n) <= N_MAX);
endmodule

// File: rtl/pgm_vfy_track.sv
module pgm_vfy_track #(
  parameter int PAGE_WORDS = 64,
  parameter int WIDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_start,
  input  logic              word_done,
  input  logic              word_ok,
  output logic [WIDX_W-1:0] widx,
  output logic              last,
  output logic              miss
);
  always_ff @(posedge clk) begin
    if (rst) begin
      widx <= '0;
      miss <= 1'b0;
    end else if (pass_start) begin
      widx <= '0;
      miss <= 1'b0;
    end else if (word_done) begin
      if (!last)    widx <= widx + 1'b1;
      if (!word_ok) miss <= 1'b1;
    end
  end

  assign last = (32'(widx) == PAGE_WORDS - 1);

  // R6
  word_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(widx) < PAGE_WORDS);
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_pgm_pkg::*;
#(
  parameter int PAGE_WORDS  = 64,
  parameter int CNT_W       = 16,
  parameter int N_MAX       = 1000,
  parameter int SHORT_LOOPS = 6,
  parameter int T_ARM       = 100,
  parameter int T_PREP      = 5000,
  parameter int T_SHORT     = 3000,
  parameter int T_LONG      = 20000,
  parameter int T_ADD       = 1000,
  parameter int T_HOLD      = 500,
  parameter int T_UNPREP    = 500,
  parameter int T_VSET      = 400,
  parameter int T_VGAP      = 200,
  parameter int T_VCLR      = 200,
  parameter int T_DISARM    = 10000,
  localparam int WIDX_W     = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_ack_i,
  input  logic              rd_valid_i,
  input  logic              rd_ok_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              wdt_en_o,
  output logic              arm_o,
  output logic              prep_o,
  output logic              pulse_o,
  output logic              vfy_o,
  output logic              add_pass_o,
  output logic              load_req_o,
  output logic              dummy_wr_o,
  output logic              rd_req_o,
  output logic [WIDX_W-1:0] vfy_word_o
);
  localparam int LOOP_W = $clog2(N_MAX + 1);
  localparam logic [CNT_W-1:0] L_ARM    = CNT_W'(T_ARM - 1);
  localparam logic [CNT_W-1:0] L_PREP   = CNT_W'(T_PREP - 1);
  localparam logic [CNT_W-1:0] L_SHORT  = CNT_W'(T_SHORT - 1);
  localparam logic [CNT_W-1:0] L_LONG   = CNT_W'(T_LONG - 1);
  localparam logic [CNT_W-1:0] L_ADD    = CNT_W'(T_ADD - 1);
  localparam logic [CNT_W-1:0] L_HOLD   = CNT_W'(T_HOLD - 1);
  localparam logic [CNT_W-1:0] L_UNPREP = CNT_W'(T_UNPREP - 1);
  localparam logic [CNT_W-1:0] L_VSET   = CNT_W'(T_VSET - 1);
  localparam logic [CNT_W-1:0] L_VGAP   = CNT_W'(T_VGAP - 1);
  localparam logic [CNT_W-1:0] L_VCLR   = CNT_W'(T_VCLR - 1);
  localparam logic [CNT_W-1:0] L_DISARM = CNT_W'(T_DISARM - 1);

  seq_state_t       st, nxt;
  logic             tld, tz;
  logic [CNT_W-1:0] tval;
  logic             lp_init, lp_step, long_sel, add_ok, at_max;
  logic             pass_start, word_done, last, miss;
  logic             set_add, set_fail, addm, res_fail;

  pgm_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tld), .val(tval), .zero(tz)
  );

  pgm_loop_ctr #(.N_MAX(N_MAX), .SHORT_LOOPS(SHORT_LOOPS), .LOOP_W(LOOP_W)) u_loop (
    .clk(clk), .rst(rst), .init(lp_init), .step(lp_step),
    .long_sel(long_sel), .add_ok(add_ok), .at_max(at_max)
  );

  assign word_done = (st == S_RD) && rd_valid_i;

  pgm_vfy_track #(.PAGE_WORDS(PAGE_WORDS), .WIDX_W(WIDX_W)) u_vfy (
    .clk(clk), .rst(rst), .pass_start(pass_start), .word_done(word_done),
    .word_ok(rd_ok_i), .widx(vfy_word_o), .last(last), .miss(miss)
  );

  always_comb begin
    nxt = st; tld = 1'b0; tval = '0;
    lp_init = 1'b0; lp_step = 1'b0; pass_start = 1'b0;
    set_add = 1'b0; set_fail = 1'b0;
    unique case (st)
      S_IDLE:   if (start) begin nxt = S_ARM; tld = 1'b1; tval = L_ARM; lp_init = 1'b1; end
      S_ARM:    if (tz) nxt = S_LOAD;
      S_LOAD:   if (load_ack_i) begin nxt = S_PREP; tld = 1'b1; tval = L_PREP; end
      S_PREP:   if (tz) begin
                  nxt = S_PULSE; tld = 1'b1;
                  tval = addm ? L_ADD : (long_sel ? L_LONG : L_SHORT);
                end
      S_PULSE:  if (tz) begin nxt = S_HOLD; tld = 1'b1; tval = L_HOLD; end
      S_HOLD:   if (tz) begin nxt = S_UNPREP; tld = 1'b1; tval = L_UNPREP; end
      S_UNPREP: if (tz) begin
                  tld = 1'b1;
                  if (addm) begin nxt = S_DISARM; tval = L_DISARM; end
                  else begin nxt = S_VSET; tval = L_VSET; pass_start = 1'b1; end
                end
      S_VSET:   if (tz) nxt = S_DMY;
      S_DMY:    begin nxt = S_VGAP; tld = 1'b1; tval = L_VGAP; end
      S_VGAP:   if (tz) nxt = S_RD;
      S_RD:     if (rd_valid_i) begin
                  if (last) begin nxt = S_VCLR; tld = 1'b1; tval = L_VCLR; end
                  else nxt = S_DMY;
                end
      S_VCLR:   if (tz) begin
                  if (!miss) begin
                    if (add_ok) begin nxt = S_LOAD; set_add = 1'b1; end
                    else begin nxt = S_DISARM; tld = 1'b1; tval = L_DISARM; end
                  end else if (at_max) begin
                    nxt = S_DISARM; tld = 1'b1; tval = L_DISARM; set_fail = 1'b1;
                  end else begin
                    nxt = S_LOAD; lp_step = 1'b1;
                  end
                end
      S_DISARM: if (tz) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; addm <= 1'b0; res_fail <= 1'b0;
      busy_o <= 1'b0; wdt_en_o <= 1'b0; done_o <= 1'b0; fail_o <= 1'b0;
      arm_o <= 1'b0; prep_o <= 1'b0; pulse_o <= 1'b0; vfy_o <= 1'b0;
      load_req_o <= 1'b0; dummy_wr_o <= 1'b0; rd_req_o <= 1'b0;
    end else begin
      st <= nxt;
      if (lp_init) begin addm <= 1'b0; res_fail <= 1'b0; end
      if (set_add)  addm <= 1'b1;
      if (set_fail) res_fail <= 1'b1;
      busy_o     <= (nxt != S_IDLE);
      wdt_en_o   <= (nxt != S_IDLE);
      arm_o      <= (nxt != S_IDLE) && (nxt != S_DISARM);
      prep_o     <= (nxt == S_PREP) || (nxt == S_PULSE) || (nxt == S_HOLD);
      pulse_o    <= (nxt == S_PULSE);
      vfy_o      <= (nxt == S_VSET) || (nxt == S_DMY) || (nxt == S_VGAP) || (nxt == S_RD);
      load_req_o <= (nxt == S_LOAD);
      dummy_wr_o <= (nxt == S_DMY);
      rd_req_o   <= (nxt == S_RD);
      done_o     <= (st == S_DISARM) && tz && !res_fail;
      fail_o     <= (st == S_DISARM) && tz && res_fail;
    end
  end

  assign add_pass_o = addm;

  // R3
  prep_guard_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> prep_o);
  // R6
  vfy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    vfy_o |-> !prep_o);
  // R10
  end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o || fail_o) |-> (!arm_o && !busy_o));
  // R9
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));
  // R5
  load_before_prep_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prep_o) |-> $past(load_req_o));
endmodule

// File: tb/tb_flash_pgm_seq.sv
`timescale 1ns/1ps
module tb_flash_pgm_seq;
  localparam int PW = 4, NMAX = 8, SHORT = 3;
  localparam int T_ARM = 3, T_PREP = 3, T_SHORT = 5, T_LONG = 9, T_ADD = 2;
  localparam int T_HOLD = 2, T_UNPREP = 4, T_VSET = 3, T_VGAP = 2, T_VCLR = 2, T_DISARM = 5;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic load_ack = 1'b0, rd_valid = 1'b0, rd_ok = 1'b0;
  logic busy, done, fail, wdt_en, arm, prep, pulse, vfy, add_pass, load_req, dummy_wr, rd_req;
  logic [1:0] vfy_word;

  int n_tests = 0, n_fail = 0;
  int cur_k = 0;
  bit mon_clr = 1'b0;
  int npulse, nadd, nreq, npass, cur_pw, last_pw, psu_cnt, gap, swe_lead, trail;
  int pvlead, pvr, words, cpv, ewc;
  bit gap_on, trail_on, pvlead_on, pvr_on, cpv_on;
  int pw_err, add_err, seq_err, pv_err, wdt_err, arm_err, eng_err;
  logic p_pgm, p_psu, p_pv, p_swe, p_req, p_rd;

  always #2 clk = ~clk;

  flash_pgm_seq #(
    .PAGE_WORDS(PW), .CNT_W(8), .N_MAX(NMAX), .SHORT_LOOPS(SHORT),
    .T_ARM(T_ARM), .T_PREP(T_PREP), .T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_ADD(T_ADD),
    .T_HOLD(T_HOLD), .T_UNPREP(T_UNPREP), .T_VSET(T_VSET), .T_VGAP(T_VGAP),
    .T_VCLR(T_VCLR), .T_DISARM(T_DISARM)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .load_ack_i(load_ack), .rd_valid_i(rd_valid),
    .rd_ok_i(rd_ok), .busy_o(busy), .done_o(done), .fail_o(fail), .wdt_en_o(wdt_en),
    .arm_o(arm), .prep_o(prep), .pulse_o(pulse), .vfy_o(vfy), .add_pass_o(add_pass),
    .load_req_o(load_req), .dummy_wr_o(dummy_wr), .rd_req_o(rd_req), .vfy_word_o(vfy_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Emulated data engine: answers one negedge after each request.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_clr) begin
        ewc = 0; eng_err = 0; load_ack = 1'b0; rd_valid = 1'b0;
      end else begin
        load_ack = load_req && !load_ack;
        if (rd_req && !rd_valid) begin
          rd_valid = 1'b1;
          if (int'(vfy_word) != ewc) eng_err++;
          rd_ok = !((npulse < cur_k) && (ewc == npulse % PW));
          ewc = (ewc + 1) % PW;
        end else begin
          rd_valid = 1'b0;
        end
      end
    end
  end

  // Phase monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (mon_clr) begin
      npulse = 0; nadd = 0; nreq = 0; npass = 0; cur_pw = 0; last_pw = 0; psu_cnt = 0;
      gap = 0; swe_lead = 0; trail = 0; pvlead = 0; pvr = 0; words = 0; cpv = 0;
      gap_on = 0; trail_on = 0; pvlead_on = 0; pvr_on = 0; cpv_on = 0;
      pw_err = 0; add_err = 0; seq_err = 0; pv_err = 0; wdt_err = 0; arm_err = 0;
      p_pgm = 0; p_psu = 0; p_pv = 0; p_swe = 0; p_req = 0; p_rd = 0;
    end else begin
      if (wdt_en !== busy) wdt_err++;
      if (arm && nreq == 0 && !load_req) swe_lead++;
      if (load_req && !p_req) nreq++;
      if (pulse) cur_pw++;
      if (!pulse && p_pgm) begin
        last_pw = cur_pw;
        if (add_pass) begin
          nadd++;
          if (cur_pw != T_ADD) add_err++;
        end else begin
          npulse++;
          if (cur_pw != ((npulse <= SHORT) ? T_SHORT : T_LONG)) pw_err++;
        end
        cur_pw = 0;
      end
      if (prep) psu_cnt++;
      if (gap_on) begin
        if (arm && !prep && !vfy && !load_req) gap++;
        else begin if (gap != T_UNPREP) seq_err++; gap_on = 0; end
      end
      if (!prep && p_psu) begin
        if (psu_cnt != last_pw + T_PREP + T_HOLD) seq_err++;
        psu_cnt = 0; gap_on = 1; gap = 1;
      end
      if (vfy && !p_pv) begin npass++; words = 0; pvlead = 1; pvlead_on = 1; end
      else if (pvlead_on) begin
        if (vfy && !dummy_wr) pvlead++;
        else begin if (pvlead != T_VSET) pv_err++; pvlead_on = 0; end
      end
      if (pvr_on) begin
        if (vfy && !dummy_wr && !rd_req) pvr++;
        else begin if (pvr != T_VGAP) pv_err++; pvr_on = 0; end
      end
      if (dummy_wr) begin pvr_on = 1; pvr = 0; end
      if (rd_req && !p_rd) words++;
      if (cpv_on) begin
        if (arm && !vfy && !load_req) cpv++;
        else begin if (cpv != T_VCLR) pv_err++; cpv_on = 0; end
      end
      if (!vfy && p_pv) begin
        if (words != PW) pv_err++;
        cpv_on = 1; cpv = 1;
      end
      if (trail_on) begin
        if (busy && !arm) trail++;
        else begin if (trail != T_DISARM) arm_err++; trail_on = 0; end
      end
      if (!arm && p_swe) begin trail_on = 1; trail = 1; end
      p_pgm = pulse; p_psu = prep; p_pv = vfy; p_swe = arm; p_req = load_req; p_rd = rd_req;
    end
  end

  task automatic run(input int k);
    int cyc;
    bit got_done, got_fail;
    int exp_np, exp_add;
    cur_k = k;
    mon_clr = 1'b1;
    @(negedge clk); @(negedge clk);
    mon_clr = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || fail) && cyc < LIMIT) begin @(negedge clk); cyc++; end
    got_done = done; got_fail = fail;
    @(negedge clk); @(negedge clk);
    if (cyc >= LIMIT) check(1'b0, "R10 watchdog", cyc, LIMIT);
    exp_np  = (k <= NMAX) ? k : NMAX;
    exp_add = (k <= SHORT) ? 1 : 0;
    check(got_done == (k <= NMAX), "R10 done result", got_done, k <= NMAX);
    check(got_fail == (k > NMAX), "R9 fail result", got_fail, k > NMAX);
    check(npulse == exp_np, "R7 normal pulse count", npulse, exp_np);
    check(npass == exp_np, "R6 verify pass count", npass, exp_np);
    check(nadd == exp_add, "R8 additional pulse count", nadd, exp_add);
    check(add_err == 0, "R8 additional pulse width", add_err, 0);
    check(pw_err == 0, "R4 pulse width by loop", pw_err, 0);
    check(seq_err == 0, "R3 setup/hold/unprep timing", seq_err, 0);
    check(pv_err == 0, "R6 verify phase timing and words", pv_err, 0);
    check(eng_err == 0, "R6 verify word index", eng_err, 0);
    check(nreq == exp_np + exp_add, "R5 load handshakes", nreq, exp_np + exp_add);
    check(swe_lead == T_ARM, "R2 arm lead time", swe_lead, T_ARM);
    check(wdt_err == 0, "R2 watchdog enable follows busy", wdt_err, 0);
    check(arm_err == 0 && !busy, "R10 disarm wait", arm_err, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check({busy, done, fail, wdt_en, arm, prep, pulse, vfy, add_pass, load_req, dummy_wr, rd_req} == 12'd0,
          "R1 outputs during reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, fail, wdt_en, arm, prep, pulse, vfy, add_pass, load_req, dummy_wr, rd_req} == 12'd0,
          "R1 outputs after reset", 0, 0);
    for (int k = 1; k <= NMAX + 1; k++) run(k);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule